// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a serial test port for a chip's pad ring. It is clocked by its own test clock and steered by a mode-select line through the standard sixteen-state controller. It holds a 3-bit instruction. The instruction picks one of three data paths to place between the serial input and output: a single-bit bypass stage, a 32-bit identification word, or a boundary register whose length is a parameter. The boundary register samples the chip's pin values. It can also take over the functional outputs with a pattern shifted in beforehand, or float every functional output.

There is no test reset pin. The only reset is an asynchronous power-on reset. After power-on, the port can always be returned to its reset state by holding mode-select high. The power-on reset and the reset state both leave the identification instruction active. Boundary cells above the pin count are filler cells and always capture 1.

Top module: `scan_tap`

## Requirements
- R1: Five rising edges of `tck` with `tms` high bring the controller to its reset state from any state. In that state the active instruction becomes 001 (identification), and it is also 001 after power-on.
- R2: `tdo_oe` is 1 only while the controller is in the instruction-shift or data-shift state. `tdo` and `tdo_oe` change on the falling edge of `tck`, and `tdo` is 0 whenever `tdo_oe` is 0.
- R3: On capture, the instruction shift stage loads 3'b001. Bit 0 leaves first on `tdo`, so the first three bits seen are 1, 0, 0.
- R4: A code shifted into the instruction stage has no effect on the outputs until the controller leaves the instruction-update state.
- R5: Under instruction 001, the data path captures the parameter `ID_VALUE` (bit 0 = 1) and shifts it out least significant bit first.
- R6: Instruction 111 selects a one-bit stage that captures 0. Codes 011, 101 and 110 act the same way, so `tdi` reappears on `tdo` one shift later.
- R7: Under instruction 010, `pad_hiz` is 1 and the boundary register is the data path. Under every other instruction `pad_hiz` is 0.
- R8: Under instructions 000, 010 and 100, capture loads `pin_in` into boundary cells [PIN_CNT-1:0] and 1 into every cell above. Shifting is from cell 0 first.
- R9: On leaving the data-update state under 000, 010 or 100, the update latch takes boundary cells [PIN_CNT-1:0]. `pad_out` carries the latch under 000 and `func_out` under every other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| pin_in | input | PIN_CNT | Pin levels captured into the boundary register |
| func_out | input | PIN_CNT | Values the core wants on its output pads |
| pad_out | output | PIN_CNT | Values presented to the output pads |
| pad_hiz | output | 1 | Forces all functional pad drivers off |

## Verification
Controller state, instruction and data registers change on the rising edge that ends a cycle. `tdo` and `tdo_oe` follow on the next falling edge, half a period later. The bench drives each step just after a falling edge, updates its model at the rising edge, and compares every output a quarter period after the following falling edge, so both edge domains have settled. A new instruction reaches `pad_out` and `pad_hiz` only on the rising edge that leaves the update state. The bench therefore checks these outputs once in that state, before the edge, and again after it.

// File: rtl/scan_tap.sv
module scan_tap #(
  parameter int          PIN_CNT  = 6,
  parameter int          BSR_LEN  = 9,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_0F3D
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [PIN_CNT-1:0] pin_in,
  input  logic [PIN_CNT-1:0] func_out,
  output logic [PIN_CNT-1:0] pad_out,
  output logic               pad_hiz
);
  localparam logic [3:0] S_RESET = 4'd0,  S_IDLE  = 4'd1,  S_DRSEL = 4'd2,  S_DRCAP = 4'd3,
                         S_DRSH  = 4'd4,  S_DREX1 = 4'd5,  S_DRPAU = 4'd6,  S_DREX2 = 4'd7,
                         S_DRUPD = 4'd8,  S_IRSEL = 4'd9,  S_IRCAP = 4'd10, S_IRSH  = 4'd11,
                         S_IREX1 = 4'd12, S_IRPAU = 4'd13, S_IREX2 = 4'd14, S_IRUPD = 4'd15;
  localparam logic [2:0] OP_DRIVE = 3'b000, OP_IDENT = 3'b001, OP_FLOAT = 3'b010, OP_PEEK = 3'b100;

  logic [3:0]         state, nxt;
  logic [2:0]         ir_sh, ir_q;
  logic               byp;
  logic [31:0]        id_sh;
  logic [BSR_LEN-1:0] bsr_sh, bsr_cap;
  logic [PIN_CNT-1:0] upd_q;
  logic               sel_bsr, sel_id, dr_lsb;

  always_comb begin
    case (state)
      S_RESET: nxt = tms ? S_RESET : S_IDLE;
      S_IDLE:  nxt = tms ? S_DRSEL : S_IDLE;
      S_DRSEL: nxt = tms ? S_IRSEL : S_DRCAP;
      S_DRCAP: nxt = tms ? S_DREX1 : S_DRSH;
      S_DRSH:  nxt = tms ? S_DREX1 : S_DRSH;
      S_DREX1: nxt = tms ? S_DRUPD : S_DRPAU;
      S_DRPAU: nxt = tms ? S_DREX2 : S_DRPAU;
      S_DREX2: nxt = tms ? S_DRUPD : S_DRSH;
      S_DRUPD: nxt = tms ? S_DRSEL : S_IDLE;
      S_IRSEL: nxt = tms ? S_RESET : S_IRCAP;
      S_IRCAP: nxt = tms ? S_IREX1 : S_IRSH;
      S_IRSH:  nxt = tms ? S_IREX1 : S_IRSH;
      S_IREX1: nxt = tms ? S_IRUPD : S_IRPAU;
      S_IRPAU: nxt = tms ? S_IREX2 : S_IRPAU;
      S_IREX2: nxt = tms ? S_IRUPD : S_IRSH;
      default: nxt = tms ? S_DRSEL : S_IDLE;
    endcase
  end

  assign sel_bsr = (ir_q == OP_DRIVE) || (ir_q == OP_FLOAT) || (ir_q == OP_PEEK);
  assign sel_id  = (ir_q == OP_IDENT);
  assign dr_lsb  = sel_bsr ? bsr_sh[0] : (sel_id ? id_sh[0] : byp);

  always_comb begin
    bsr_cap = '1;
    bsr_cap[PIN_CNT-1:0] = pin_in;
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      state <= S_RESET;
      ir_sh <= OP_IDENT;
      ir_q  <= OP_IDENT;
      byp   <= 1'b0;
      id_sh <= '0;
      bsr_sh <= '0;
      upd_q <= '0;
    end else begin
      state <= nxt;
      if (state == S_IRCAP)    ir_sh <= 3'b001;
      else if (state == S_IRSH) ir_sh <= {tdi, ir_sh[2:1]};
      if (state == S_RESET)     ir_q <= OP_IDENT;
      else if (state == S_IRUPD) ir_q <= ir_sh;
      if (state == S_DRCAP) begin
        byp    <= 1'b0;
        id_sh  <= ID_VALUE;
        bsr_sh <= bsr_cap;
      end else if (state == S_DRSH) begin
        if (sel_bsr)     bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        else if (sel_id) id_sh  <= {tdi, id_sh[31:1]};
        else             byp    <= tdi;
      end
      if (state == S_DRUPD && sel_bsr) upd_q <= bsr_sh[PIN_CNT-1:0];
    end
  end

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == S_IRSH) || (state == S_DRSH);
      tdo    <= (state == S_IRSH) ? ir_sh[0] : ((state == S_DRSH) ? dr_lsb : 1'b0);
    end
  end

  assign pad_out = (ir_q == OP_DRIVE) ? upd_q : func_out;
  assign pad_hiz = (ir_q == OP_FLOAT);
endmodule

module scan_tap_chk #(
  parameter int PIN_CNT = 6
) (
  input logic               tck,
  input logic               por_n,
  input logic [3:0]         state,
  input logic [2:0]         ir_q,
  input logic [2:0]         ir_sh,
  input logic [PIN_CNT-1:0] upd_q,
  input logic               tdo_oe,
  input logic               pad_hiz
);
  localparam logic [3:0] C_RESET = 4'd0, C_DRSH = 4'd4, C_DRUPD = 4'd8,
                         C_IRCAP = 4'd10, C_IRSH = 4'd11, C_IRUPD = 4'd15;

  // R1
  reset_loads_ident_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_RESET) |=> (ir_q == 3'b001));
  // R2
  tdo_only_in_shift_chk: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (state == C_DRSH || state == C_IRSH));
  // R3
  ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state == C_IRCAP) |=> (ir_sh[1:0] == 2'b01));
  // R4
  ir_holds_outside_update_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state != C_IRUPD && state != C_RESET) |=> $stable(ir_q));
  // R7
  float_starts_at_update_chk: assert property (@(posedge tck) disable iff (!por_n)
    $rose(pad_hiz) |-> ($past(state) == C_IRUPD));
  // R9
  latch_holds_outside_update_chk: assert property (@(posedge tck) disable iff (!por_n)
    (state != C_DRUPD) |=> $stable(upd_q));
endmodule

bind scan_tap scan_tap_chk #(.PIN_CNT(PIN_CNT)) chk_i (
  .tck(tck), .por_n(por_n), .state(state), .ir_q(ir_q), .ir_sh(ir_sh),
  .upd_q(upd_q), .tdo_oe(tdo_oe), .pad_hiz(pad_hiz)
);

// File: tb/scan_tap_tb.sv
module scan_tap_tb_top;
  localparam int TCK_PERIOD = 10;
  localparam int PINS = 6;
  localparam int CELLS = 9;
  localparam logic [31:0] IDV = 32'h1A5C_0F3D;

  logic tck = 0, por_n = 0, tms = 1, tdi = 1;
  logic tdo, tdo_oe, pad_hiz;
  logic [PINS-1:0] pin_in = 6'b101100, func_out = 6'b110101, pad_out;

  int errors = 0, checks = 0;
  string cur_req = "R2";

  int nx0[16] = '{1,1,3,4,4,6,6,4,1,10,11,11,13,13,11,1};
  int nx1[16] = '{0,2,9,5,5,8,7,8,2,0,12,12,15,14,15,2};
  int m_state = 0, m_len = 1;
  logic [2:0] m_ir = 3'b001, m_irs = 3'b001;
  logic [63:0] m_dr = '0;
  logic [PINS-1:0] m_upd = '0;
  logic m_tdo = 0, m_oe = 0;

  scan_tap #(.PIN_CNT(PINS), .BSR_LEN(CELLS), .ID_VALUE(IDV)) dut_i (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .func_out(func_out), .pad_out(pad_out), .pad_hiz(pad_hiz));

  always #(TCK_PERIOD/2) tck = ~tck;

  initial begin
    #(TCK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit is_bsr(input logic [2:0] c);
    return c == 3'b000 || c == 3'b010 || c == 3'b100;
  endfunction

  task automatic model_rise();
    int s = m_state;
    if (s == 0) m_ir = 3'b001;
    if (s == 10) m_irs = 3'b001;
    if (s == 11) m_irs = {tdi, m_irs[2:1]};
    if (s == 15) m_ir = m_irs;
    if (s == 3) begin
      if (m_ir == 3'b001) begin m_dr = {32'd0, IDV}; m_len = 32; end
      else if (is_bsr(m_ir)) begin m_dr = '1; m_dr[PINS-1:0] = pin_in; m_len = CELLS; end
      else begin m_dr = '0; m_len = 1; end
    end
    if (s == 4) begin m_dr = m_dr >> 1; m_dr[m_len-1] = tdi; end
    if (s == 8 && is_bsr(m_ir)) m_upd = m_dr[PINS-1:0];
    m_state = tms ? nx1[s] : nx0[s];
  endtask

  task automatic step(input logic t, input logic d);
    tms = t; tdi = d;
    @(posedge tck); model_rise();
    @(negedge tck);
    m_oe  = (m_state == 4 || m_state == 11);
    m_tdo = (m_state == 11) ? m_irs[0] : ((m_state == 4) ? m_dr[0] : 1'b0);
    #(TCK_PERIOD/4);
    check(tdo_oe === m_oe, {cur_req, "/R2 tdo_oe"}, 64'(tdo_oe), 64'(m_oe));
    check(tdo === m_tdo, {cur_req, "/R2 tdo"}, 64'(tdo), 64'(m_tdo));
    check(pad_hiz === (m_ir == 3'b010), {cur_req, "/R7 pad_hiz"}, 64'(pad_hiz), 64'(m_ir == 3'b010));
    check(pad_out === ((m_ir == 3'b000) ? m_upd : func_out), {cur_req, "/R9 pad_out"},
          64'(pad_out), 64'((m_ir == 3'b000) ? m_upd : func_out));
  endtask

  // from idle; ends in the instruction-update state
  task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      seen[i] = tdo;
      step(i == 2, code[i]);
    end
    step(1, 0);
  endtask

  // from idle; back in idle
  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    logic [2:0]  seen;
    logic [63:0] q;
    logic [2:0]  byp_codes[4] = '{3'b111, 3'b011, 3'b101, 3'b110};
    repeat (3) @(posedge tck);
    @(negedge tck); por_n = 1; #(TCK_PERIOD/4);
    check(tdo_oe === 1'b0, "R2 reset oe", 64'(tdo_oe), 0);
    check(pad_hiz === 1'b0, "R7 reset hiz", 64'(pad_hiz), 0);
    check(pad_out === func_out, "R9 reset pad", 64'(pad_out), 64'(func_out));

    cur_req = "R5";
    step(0, 0);
    scan_dr(32, 64'h0, q);
    check(q[31:0] === IDV, "R5 id after power-on (R1 default)", q, 64'(IDV));

    cur_req = "R6";
    foreach (byp_codes[k]) begin
      load_ir(byp_codes[k], seen);
      check(seen === 3'b001, "R3 ir capture bits", 64'(seen), 64'(3'b001));
      step(0, 0);
      scan_dr(4, 64'b1011, q);
      check(q[3:0] === 4'b0110, "R6 bypass delay", q, 64'b0110);
    end

    cur_req = "R7";
    pin_in = 6'b011010;
    load_ir(3'b010, seen);
    check(pad_hiz === 1'b0, "R4 float waits for update", 64'(pad_hiz), 0);
    step(0, 0);
    check(pad_hiz === 1'b1, "R7 float active", 64'(pad_hiz), 1);
    scan_dr(CELLS, 64'h0, q);
    check(q[CELLS-1:0] === {3'b111, 6'b011010}, "R8 capture under float", q, 64'({3'b111, 6'b011010}));

    cur_req = "R8";
    pin_in = 6'b100101;
    load_ir(3'b100, seen);
    step(0, 0);
    check(pad_hiz === 1'b0, "R7 float released", 64'(pad_hiz), 0);
    scan_dr(CELLS, 64'h013, q);
    check(q[CELLS-1:0] === {3'b111, 6'b100101}, "R8 capture under peek", q, 64'({3'b111, 6'b100101}));
    check(pad_out === func_out, "R9 peek keeps func_out", 64'(pad_out), 64'(func_out));

    cur_req = "R9";
    load_ir(3'b000, seen);
    check(pad_out === func_out, "R4 drive waits for update", 64'(pad_out), 64'(func_out));
    step(0, 0);
    check(pad_out === 6'b010011, "R9 drive latch", 64'(pad_out), 64'(6'b010011));
    func_out = 6'b001110;
    scan_dr(CELLS, 64'h02A, q);
    check(pad_out === 6'b101010, "R9 new latch", 64'(pad_out), 64'(6'b101010));

    cur_req = "R1";
    load_ir(3'b111, seen);
    step(0, 0);
    step(1, 0); step(0, 0); step(0, 1);
    check(tdo_oe === 1'b1, "R2 oe in shift", 64'(tdo_oe), 1);
    repeat (5) step(1, 0);
    check(tdo_oe === 1'b0, "R1 left shift", 64'(tdo_oe), 0);
    check(pad_out === func_out, "R1 default instr pads", 64'(pad_out), 64'(func_out));
    step(0, 0);
    scan_dr(32, 64'h0, q);
    check(q[31:0] === IDV, "R1 id after five ones", q, 64'(IDV));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule